// File: doc/BRIEF.md
# Delta-Sigma ADC Result Reader

This block is a serial master that fetches one conversion result from a 22-bit delta-sigma converter whose data output also signals that a conversion is finished. A one-cycle `start` pulse pulls chip select low. The block then watches the shared line. When the line drops low, a result is ready, and the block runs one unbroken burst of serial clocks. It captures each bit on a rising clock edge and presents the result on a parallel port together with a one-cycle strobe.

The `idle_hi` input is static and selects the clock resting level. With the clock resting high, the ready level is read directly from the line before the first falling edge, and the frame takes 24 pulses. With the clock resting low, the ready bit comes in as the first captured bit, and the frame takes 25 pulses. In both modes the captured frame holds the low-side overflow flag, then the high-side overflow flag, then data bits 21 down to 0. If the line stays high too long, the block gives up and raises a timeout pulse. In the resting-low mode, a first captured bit that reads high aborts the frame.

Top module: `adc_rd_ctrl`

## Requirements
- R1: After reset, `cs_n` is 1, `sck` equals `idle_hi`, and `valid`, `err_tmo` and `err_rdy` are 0.
- R2: A `start` pulse in idle drives `cs_n` to 0 on the next clock. While `sdo_rdy` stays 1, `sck` does not toggle.
- R3: If `sdo_rdy` stays 1 for TIMEOUT clock cycles with `cs_n` low, `cs_n` returns to 1 and `err_tmo` pulses for one cycle. No `valid` is given and no `sck` edge occurs.
- R4: With `idle_hi`=1, `sck` rests at 1 and a completed frame contains exactly 24 rising `sck` edges.
- R5: With `idle_hi`=0, `sck` rests at 0 and a completed frame contains exactly 25 rising `sck` edges. The first capture is the ready bit and is discarded.
- R6: During a frame, every `sck` level lasts exactly DIV system clock cycles.
- R7: Bits are captured at rising `sck` edges. Frame order after the ready indication is `ovf_lo`, then `ovf_hi`, then data bit 21 down to bit 0. `result` is the 22-bit two's-complement data sign-extended to 24 bits.
- R8: With `idle_hi`=0, if the line reads 1 at the first capture, the frame aborts. `cs_n` goes to 1, `sck` stays 0, `err_rdy` pulses for one cycle, no rising edge occurs and no `valid` is given.
- R9: `cs_n` rises no sooner than DIV system cycles after the last rising `sck` edge.
- R10: `valid` is a one-cycle pulse, raised in the same cycle that `cs_n` returns to 1 after a completed frame.
- R11: A `start` pulse while a frame is in progress is ignored. No second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request one read (taken only when idle) |
| idle_hi | input | 1 | Static clock resting level: 1 high, 0 low |
| sdo_rdy | input | 1 | Shared ready/data line from the converter |
| sck | output | 1 | Serial clock to the converter |
| cs_n | output | 1 | Active-low chip select |
| result | output | 24 | Sign-extended conversion value |
| ovf_lo | output | 1 | Low-side overflow flag of last frame |
| ovf_hi | output | 1 | High-side overflow flag of last frame |
| valid | output | 1 | One-cycle strobe on a completed frame |
| err_tmo | output | 1 | One-cycle pulse on a ready timeout |
| err_rdy | output | 1 | One-cycle pulse on a not-ready abort (resting-low mode) |

## Verification
`cs_n` falls one clock after `start` is sampled. A timeout completes TIMEOUT clocks after that, so the bench counts low `cs_n` samples and expects exactly TIMEOUT of them, with `err_tmo` high at the first high sample. In a frame, `result`, the flags, `valid` and the rising `cs_n` all appear together, 2·DIV·N + DIV clocks after the ready level is seen (N is 24 or 25). The bench waits for `valid` rather than for a fixed count and measures half periods and the release gap in simulated time. A converter model drives a new bit after every falling `sck` edge, and all outputs are sampled on the falling system clock edge.

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl #(
  parameter int DIV     = 2,
  parameter int TIMEOUT = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        idle_hi,
  input  logic        sdo_rdy,
  output logic        sck,
  output logic        cs_n,
  output logic [23:0] result,
  output logic        ovf_lo,
  output logic        ovf_hi,
  output logic        valid,
  output logic        err_tmo,
  output logic        err_rdy
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int TW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_SHIFT} st_t;

  st_t         st;
  logic        mode_q;
  logic [PW-1:0] ph;
  logic [TW-1:0] wc;
  logic [5:0]  tg;
  logic [23:0] sr;

  wire       ph_end  = (ph == PW'(DIV - 1));
  wire [5:0] tg_last = mode_q ? 6'd48 : 6'd50;
  wire       rise    = ph_end && (tg != tg_last) && !sck;
  wire       abort   = rise && !mode_q && (tg == 6'd0) && sdo_rdy;
  wire       finish  = ph_end && (tg == tg_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      mode_q  <= 1'b0;
      sck     <= idle_hi;
      cs_n    <= 1'b1;
      ph      <= '0;
      wc      <= '0;
      tg      <= '0;
      sr      <= '0;
      result  <= '0;
      ovf_lo  <= 1'b0;
      ovf_hi  <= 1'b0;
      valid   <= 1'b0;
      err_tmo <= 1'b0;
      err_rdy <= 1'b0;
    end else begin
      valid   <= 1'b0;
      err_tmo <= 1'b0;
      err_rdy <= 1'b0;
      case (st)
        S_IDLE: begin
          sck <= idle_hi;
          if (start) begin
            mode_q <= idle_hi;
            cs_n   <= 1'b0;
            wc     <= '0;
            st     <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (!sdo_rdy) begin
            st <= S_SHIFT;
            ph <= '0;
            tg <= '0;
          end else if (wc == TW'(TIMEOUT - 1)) begin
            st      <= S_IDLE;
            cs_n    <= 1'b1;
            err_tmo <= 1'b1;
          end else begin
            wc <= wc + 1'b1;
          end
        end
        S_SHIFT: begin
          ph <= ph_end ? '0 : ph + 1'b1;
          if (abort) begin
            st      <= S_IDLE;
            cs_n    <= 1'b1;
            sck     <= 1'b0;
            err_rdy <= 1'b1;
          end else if (finish) begin
            st     <= S_IDLE;
            cs_n   <= 1'b1;
            valid  <= 1'b1;
            result <= {{2{sr[21]}}, sr[21:0]};
            ovf_lo <= sr[23];
            ovf_hi <= sr[22];
          end else if (ph_end) begin
            sck <= ~sck;
            tg  <= tg + 1'b1;
            if (rise) sr <= {sr[22:0], sdo_rdy};
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
  p_valid_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (cs_n && !$past(cs_n)));
  p_no_clk_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT) |=> (sck == $past(sck)));
  p_tmo_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    err_tmo |-> (cs_n && $past(st == S_WAIT) && !valid));
  p_abort_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_rdy |-> (cs_n && !sck && !mode_q && !valid));
  p_idle_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_IDLE) && $past(st == S_IDLE)) |-> (sck == $past(idle_hi)));
endmodule

// File: tb/adc_rd_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_rd_ctrl_tb_top;
  localparam int DIV = 2;
  localparam int TIMEOUT = 40;
  localparam time TCLK = 5ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic idle_hi = 1'b1;
  logic rdy_lvl = 1'b1;
  logic [23:0] fbits = '0;
  logic sck, cs_n, ovf_lo, ovf_hi, valid, err_tmo, err_rdy;
  logic [23:0] result;
  logic sdo;

  int checks = 0;
  int fails = 0;
  int fidx = 0;
  int rises = 0;
  int bad_half = 0;
  bit have_last = 0;
  logic sck_prev = 1'b0;
  time t_last = 0;
  time t_rise = 0;
  time t_csr = 0;

  always #2.5 clk = ~clk;

  adc_rd_ctrl #(.DIV(DIV), .TIMEOUT(TIMEOUT)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .idle_hi(idle_hi), .sdo_rdy(sdo),
    .sck(sck), .cs_n(cs_n), .result(result), .ovf_lo(ovf_lo), .ovf_hi(ovf_hi),
    .valid(valid), .err_tmo(err_tmo), .err_rdy(err_rdy));

  // converter model: new bit after each falling sck edge while selected
  always @(negedge sck or posedge cs_n)
    if (cs_n) fidx <= 0;
    else      fidx <= fidx + 1;

  assign sdo = cs_n ? 1'b1 :
               (fidx == 0) ? rdy_lvl :
               (fidx <= 24) ? fbits[24 - fidx] : 1'b1;

  always @(sck or cs_n) begin
    if (rst_n && !cs_n && (sck !== sck_prev)) begin
      if (have_last && ($time - t_last != DIV * TCLK)) bad_half++;
      t_last = $time;
      have_last = 1;
      if (sck) begin
        rises++;
        t_rise = $time;
      end
    end
    if (cs_n) have_last = 0;
    sck_prev = sck;
  end

  always @(posedge cs_n) t_csr = $time;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  function automatic logic [21:0] pat(input int i);
    if (i < 22) return 22'(1) << i;
    case (i - 22)
      0: return 22'h000000;
      1: return 22'h3FFFFF;
      2: return 22'h1FFFFF;
      3: return 22'h200000;
      4: return 22'h155555;
      5: return 22'h2AAAAA;
      default: return 22'h000001;
    endcase
  endfunction

  task automatic frame(input bit m, input bit ol, input bit oh, input logic [21:0] d, input int dly);
    int r0, h0, n;
    logic [23:0] exp;
    idle_hi = m;
    @(negedge clk); @(negedge clk);
    check(sck === m, m ? "R4 rest level" : "R5 rest level", 32'(sck), 32'(m));
    fbits = {ol, oh, d};
    rdy_lvl = 1'b1;
    r0 = rises;
    h0 = bad_half;
    start = 1'b1; @(negedge clk); start = 1'b0;
    check(cs_n == 1'b0, "R2 select", 32'(cs_n), 0);
    repeat (dly) @(negedge clk);
    check(rises == r0, "R2 no clocks before ready", 32'(rises - r0), 0);
    rdy_lvl = 1'b0;
    @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;   // R11 busy request
    n = 0;
    while (!valid && n < 1000) begin @(negedge clk); n++; end
    rdy_lvl = 1'b1;
    exp = {{2{d[21]}}, d};
    check(valid && result == exp, "R7 result", 32'(result), 32'(exp));
    check(ovf_lo == ol && ovf_hi == oh, "R7 flags", {30'd0, ovf_lo, ovf_hi}, {30'd0, ol, oh});
    check(rises - r0 == (m ? 24 : 25), m ? "R4 pulse count" : "R5 pulse count", 32'(rises - r0), m ? 24 : 25);
    check(bad_half == h0, "R6 half period", 32'(bad_half - h0), 0);
    check(t_csr - t_rise >= DIV * TCLK, "R9 release gap", 32'(t_csr - t_rise), 32'(DIV * TCLK));
    check(cs_n == 1'b1, "R10 release with strobe", 32'(cs_n), 1);
    @(negedge clk);
    check(!valid, "R10 strobe width", 32'(valid), 0);
    repeat (3) @(negedge clk);
    check(cs_n == 1'b1, "R11 busy start ignored", 32'(cs_n), 1);
  endtask

  task automatic timeout_run(input bit m);
    int r0, n;
    idle_hi = m;
    @(negedge clk); @(negedge clk);
    rdy_lvl = 1'b1;
    r0 = rises;
    start = 1'b1; @(negedge clk); start = 1'b0;
    n = 0;
    while (!cs_n && n < 1000) begin
      check(!valid && !err_tmo, "R3 nothing early", {30'd0, valid, err_tmo}, 0);
      n++;
      @(negedge clk);
    end
    check(n == TIMEOUT, "R3 wait length", 32'(n), 32'(TIMEOUT));
    check(err_tmo == 1'b1, "R3 timeout pulse", 32'(err_tmo), 1);
    check(rises == r0 && sck == m, "R2 no clocks during timeout", 32'(rises - r0), 0);
    @(negedge clk);
    check(err_tmo == 1'b0, "R3 pulse width", 32'(err_tmo), 0);
  endtask

  task automatic abort_run();
    int r0, n;
    idle_hi = 1'b0;
    @(negedge clk); @(negedge clk);
    rdy_lvl = 1'b1;
    r0 = rises;
    start = 1'b1; @(negedge clk); start = 1'b0;
    rdy_lvl = 1'b0;
    @(negedge clk);
    rdy_lvl = 1'b1;
    n = 0;
    while (!cs_n && n < 1000) begin @(negedge clk); n++; end
    check(err_rdy == 1'b1, "R8 abort pulse", 32'(err_rdy), 1);
    check(!valid, "R8 no strobe", 32'(valid), 0);
    check(sck == 1'b0 && rises == r0, "R8 no rising edge", 32'(rises - r0), 0);
    @(negedge clk);
    check(err_rdy == 1'b0, "R8 pulse width", 32'(err_rdy), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(cs_n == 1'b1 && sck == 1'b1, "R1 reset lines", {30'd0, cs_n, sck}, 3);
    check(!valid && !err_tmo && !err_rdy, "R1 reset strobes", {29'd0, valid, err_tmo, err_rdy}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int m = 1; m >= 0; m--) begin
      for (int i = 0; i < 29; i++) begin
        for (int f = 0; f < 4; f++) begin
          frame(m[0], f[1], f[0], pat(i), (i + f) % 4);
        end
      end
    end
    timeout_run(1'b1);
    timeout_run(1'b0);
    abort_run();
    frame(1'b0, 1'b1, 1'b0, 22'h2ABCDE, 0);
    frame(1'b1, 1'b0, 1'b1, 22'h123456, 2);
    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
  end
endmodule